// File: doc/BRIEF.md
# Supply-Monitor Reset Sequencer

This block generates the processor reset pair and a supply-threshold status flag for a board-level supervisor. It receives a synchronous supply-below-threshold bit from an external comparator, a raw active-low pushbutton, and a one-cycle watchdog-timeout request. Any of these three causes drives reset active. Reset is then held for a stretch interval, which restarts whenever a cause comes back. The status flag is different: it follows the supply only. It releases one cycle after the supply recovers, even while reset is still being held.

All timing counts ticks of a timebase. A select input chooses the tick source. One option is an internal divider that pulses once every `INT_DIV` clock cycles. The other is an external strobe. The pushbutton is accepted only after it has stayed low for `DEB_TICKS` consecutive ticks. Reset is released after `STRETCH_TICKS` ticks with no cause present. The defaults give a 1 ms tick from a 200 MHz clock, a 20 ms debounce and a 100 ms stretch.

Top module: `supply_reset_seq`

## Requirements
- R1: While `rst_n` is low, `rst_out` is 1 and `thr_low_n` is 0. After `rst_n` rises, reset stays active until `STRETCH_TICKS` ticks have been counted.
- R2: One cycle after `supply_low` is sampled high, `rst_out` is 1 and `thr_low_n` is 0. Both stay so for as long as `supply_low` is high, whatever ticks arrive.
- R3: `thr_low_n` becomes 1 one cycle after `supply_low` is sampled low, while reset may still be held.
- R4: When no cause is present, `rst_out` falls on the clock edge that samples the `STRETCH_TICKS`-th tick counted since the last cycle in which a cause was present.
- R5: A cause that reappears part-way through the stretch clears the tick count. A full `STRETCH_TICKS` ticks are needed after it goes away.
- R6: The pushbutton `pb_n` (0 = pressed) is ignored unless it is sampled low on `DEB_TICKS` consecutive tick edges. A shorter low period leaves `rst_out` at 0, and a release clears the count.
- R7: After a valid press, reset stays active for as long as `pb_n` is held low. Once it is released, reset stays active for the full stretch.
- R8: A one-cycle `wdog_req` pulse makes `rst_out` 1 on the next cycle, followed by a full stretch.
- R9: With `src_sel` = 1 the tick is `ext_tick`. With `src_sel` = 0 the tick is an internal pulse every `INT_DIV` cycles and `ext_tick` has no effect. A release therefore takes between (`STRETCH_TICKS`-1)·`INT_DIV`+1 and `STRETCH_TICKS`·`INT_DIV` cycles.
- R10: `rst_out_n` is always the complement of `rst_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low initialisation |
| supply_low | input | 1 | Comparator result, 1 = supply below trip point, synchronous |
| pb_n | input | 1 | Raw pushbutton, 0 = pressed, synchronous |
| wdog_req | input | 1 | Watchdog timeout request, one-cycle pulse |
| src_sel | input | 1 | Tick source, 0 = internal divider, 1 = external |
| ext_tick | input | 1 | External tick strobe, one cycle per tick |
| rst_out_n | output | 1 | Reset, active low |
| rst_out | output | 1 | Reset, active high |
| thr_low_n | output | 1 | Supply-threshold status, 0 = supply low |

## Verification
The assertions assume that `supply_low`, `pb_n` and `wdog_req` are already synchronous to `clk` and change only between edges. They also assume that a released reset implies a tick at the preceding edge, which holds only if the chosen tick source is stable for that cycle. The stimulus meets these assumptions. It drives every input just after the falling edge, gives `ext_tick` as single-cycle pulses, and changes `src_sel` only while a cause holds reset. An idle cycle always separates removing a cause from the next tick, so the expected release edge can be counted exactly.

// File: rtl/srs_pkg.sv
package srs_pkg;
   typedef enum logic {
      TB_INTERNAL = 1'b0,
      TB_EXTERNAL = 1'b1
   } tick_src_e;

   typedef struct packed {
      logic supply;
      logic button;
      logic wdog;
   } rst_cause_t;

   function automatic logic any_cause(input rst_cause_t c);
      return c.supply | c.button | c.wdog;
   endfunction
endpackage

// File: rtl/srs_timebase.sv
module srs_timebase #(
   parameter int unsigned INT_DIV    = 200000,
   parameter bit          EXT_CLK_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_sel,
   input  logic ext_tick,
   output logic tick
);
   import srs_pkg::*;
   localparam int unsigned DVW  = $clog2(INT_DIV);
   localparam logic [DVW-1:0] DLAST = DVW'(INT_DIV - 1);

   logic [DVW-1:0] div_q;
   logic           int_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (div_q == DLAST)
         div_q <= '0;
      else
         div_q <= div_q + 1'b1;
   end

   assign int_tick = (div_q == DLAST);

   generate
      if (EXT_CLK_EN) begin : g_sel
         tick_src_e src;
         assign src  = tick_src_e'(src_sel);
         assign tick = (src == TB_EXTERNAL) ? ext_tick : int_tick;
      end else begin : g_int
         logic unused_ext;
         assign unused_ext = src_sel ^ ext_tick;
         assign tick = int_tick;
      end
   endgenerate
endmodule

// File: rtl/srs_debounce.sv
module srs_debounce #(
   parameter int unsigned DEB_TICKS = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pb_n,
   output logic pressed
);
   localparam int unsigned DW = $clog2(DEB_TICKS + 1);
   localparam logic [DW-1:0] DFULL = DW'(DEB_TICKS);

   logic [DW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (pb_n)
         cnt_q <= '0;
      else if (tick && (cnt_q != DFULL))
         cnt_q <= cnt_q + 1'b1;
   end

   assign pressed = (cnt_q == DFULL);
endmodule

// File: rtl/srs_stretch.sv
module srs_stretch #(
   parameter int unsigned STRETCH_TICKS = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cause,
   input  logic tick,
   output logic active
);
   localparam int unsigned SW = $clog2(STRETCH_TICKS + 1);
   localparam logic [SW-1:0] SLAST = SW'(STRETCH_TICKS - 1);

   logic [SW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b1;
         cnt_q  <= '0;
      end else if (cause) begin
         active <= 1'b1;
         cnt_q  <= '0;
      end else if (active && tick) begin
         if (cnt_q == SLAST) begin
            active <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
   parameter int unsigned STRETCH_TICKS = 100,
   parameter int unsigned DEB_TICKS     = 20,
   parameter int unsigned INT_DIV       = 200000,
   parameter bit          EXT_CLK_EN    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_low,
   input  logic pb_n,
   input  logic wdog_req,
   input  logic src_sel,
   input  logic ext_tick,
   output logic rst_out_n,
   output logic rst_out,
   output logic thr_low_n
);
   import srs_pkg::*;

   generate
      if (STRETCH_TICKS < 1) begin : g_bad_stretch
         $error("STRETCH_TICKS must be at least 1");
      end
      if (DEB_TICKS < 1) begin : g_bad_deb
         $error("DEB_TICKS must be at least 1");
      end
      if (INT_DIV < 2) begin : g_bad_div
         $error("INT_DIV must be at least 2");
      end
   endgenerate

   logic       tick_w;
   logic       pb_hold;
   logic       hold_q;
   rst_cause_t cause;

   srs_timebase #(.INT_DIV(INT_DIV), .EXT_CLK_EN(EXT_CLK_EN)) u_tb (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
      .ext_tick(ext_tick), .tick(tick_w)
   );

   srs_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
      .clk(clk), .rst_n(rst_n), .tick(tick_w),
      .pb_n(pb_n), .pressed(pb_hold)
   );

   assign cause.supply = supply_low;
   assign cause.button = pb_hold;
   assign cause.wdog   = wdog_req;

   srs_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_str (
      .clk(clk), .rst_n(rst_n), .cause(any_cause(cause)),
      .tick(tick_w), .active(hold_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         thr_low_n <= 1'b0;
      else
         thr_low_n <= ~supply_low;
   end

   assign rst_out   = hold_q;
   assign rst_out_n = ~hold_q;
endmodule

// File: rtl/srs_chk.sv
module srs_chk (
   input logic clk,
   input logic rst_n,
   input logic supply_low,
   input logic wdog_req,
   input logic pb_hold,
   input logic tick,
   input logic rst_out,
   input logic rst_out_n,
   input logic thr_low_n
);
   a_r2_supply_forces: assert property (@(posedge clk) disable iff (!rst_n)
      supply_low |=> (rst_out && !rst_out_n && !thr_low_n));

   a_r3_flag_release: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_low |=> thr_low_n);

   a_r4_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_out) |-> $past(tick));

   a_r7_button_holds: assert property (@(posedge clk) disable iff (!rst_n)
      pb_hold |=> rst_out);

   a_r8_wdog_forces: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_req |=> rst_out);
endmodule

bind supply_reset_seq srs_chk u_chk (
   .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .wdog_req(wdog_req),
   .pb_hold(pb_hold), .tick(tick_w), .rst_out(rst_out),
   .rst_out_n(rst_out_n), .thr_low_n(thr_low_n)
);

// File: tb/sim_supply_reset_seq.sv
`timescale 1ns/1ps
module sim_supply_reset_seq;
   localparam int S   = 5;
   localparam int D   = 3;
   localparam int DIV = 4;

   logic clk = 1'b0;
   logic rst_n, supply_low, pb_n, wdog_req, src_sel, ext_tick;
   logic rst_out_n, rst_out, thr_low_n;
   int   n_chk = 0;
   int   n_bad = 0;

   always #2.5 clk = ~clk;

   supply_reset_seq #(.STRETCH_TICKS(S), .DEB_TICKS(D), .INT_DIV(DIV), .EXT_CLK_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .pb_n(pb_n),
      .wdog_req(wdog_req), .src_sel(src_sel), .ext_tick(ext_tick),
      .rst_out_n(rst_out_n), .rst_out(rst_out), .thr_low_n(thr_low_n)
   );

   task automatic chk(input string r, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", r, what, act, exp);
      end
      n_chk++;
      if (rst_out_n !== ~rst_out) begin
         n_bad++;
         $display("FAIL R10 complement: actual %b expected %b", rst_out_n, ~rst_out);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_tick();
      ext_tick = 1'b1;
      @(negedge clk);
      ext_tick = 1'b0;
   endtask

   task automatic release_seq(input string r);
      for (int i = 1; i < S; i++) begin
         pulse_tick();
         chk(r, "held during stretch", rst_out, 1'b1);
      end
      pulse_tick();
      chk(r, "released after stretch", rst_out, 1'b0);
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int n;
      rst_n = 1'b0; supply_low = 1'b0; pb_n = 1'b1; wdog_req = 1'b0;
      src_sel = 1'b1; ext_tick = 1'b0;
      idle(3);
      chk("R1", "reset asserted in init", rst_out, 1'b1);
      chk("R1", "flag active in init", thr_low_n, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3", "flag released after init", thr_low_n, 1'b1);
      release_seq("R1");

      // R2 / R3: supply drop, flag leads reset on recovery
      supply_low = 1'b1;
      @(negedge clk);
      chk("R2", "reset on supply low", rst_out, 1'b1);
      chk("R2", "flag on supply low", thr_low_n, 1'b0);
      for (int i = 0; i < S + 2; i++) pulse_tick();
      chk("R2", "reset held while low", rst_out, 1'b1);
      chk("R2", "flag held while low", thr_low_n, 1'b0);
      supply_low = 1'b0;
      @(negedge clk);
      chk("R3", "flag released early", thr_low_n, 1'b1);
      chk("R3", "reset still held", rst_out, 1'b1);
      release_seq("R4");

      // R5: restart sweep over every interruption point
      for (int k = 0; k < S; k++) begin
         supply_low = 1'b1; @(negedge clk);
         supply_low = 1'b0; @(negedge clk);
         for (int i = 0; i < k; i++) pulse_tick();
         chk("R5", "held before interruption", rst_out, 1'b1);
         supply_low = 1'b1; @(negedge clk);
         supply_low = 1'b0; @(negedge clk);
         release_seq("R5");
      end

      // R6: short presses sweep
      for (int len = 1; len < D; len++) begin
         pb_n = 1'b0; @(negedge clk);
         for (int i = 0; i < len; i++) pulse_tick();
         pb_n = 1'b1; idle(2);
         chk("R6", "short press ignored", rst_out, 1'b0);
         pb_n = 1'b0; @(negedge clk);
         for (int i = 0; i < D - len; i++) pulse_tick();
         pb_n = 1'b1; idle(2);
         chk("R6", "split press not summed", rst_out, 1'b0);
      end

      // R7: valid press
      pb_n = 1'b0; @(negedge clk);
      for (int i = 0; i < D; i++) pulse_tick();
      @(negedge clk);
      chk("R7", "valid press asserts", rst_out, 1'b1);
      for (int i = 0; i < S + 2; i++) pulse_tick();
      chk("R7", "held while pressed", rst_out, 1'b1);
      pb_n = 1'b1; idle(2);
      release_seq("R7");

      // R8: watchdog request
      wdog_req = 1'b1; @(negedge clk);
      wdog_req = 1'b0;
      chk("R8", "wdog asserts", rst_out, 1'b1);
      release_seq("R8");

      // R9: internal timebase, external strobe held high and ignored
      supply_low = 1'b1; src_sel = 1'b0; ext_tick = 1'b1;
      @(negedge clk);
      supply_low = 1'b0;
      n = 0;
      while (rst_out && n < 1000) begin
         @(negedge clk);
         n++;
      end
      chk("R9", "release not before window", (n >= (S - 1) * DIV + 1), 1'b1);
      chk("R9", "release within window", (n <= S * DIV), 1'b1);
      ext_tick = 1'b0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule